// File: doc/BRIEF.md
# Ring-oscillator PUF response sequencer

This block is the digital half of a ring-oscillator physical unclonable function. A challenge is shifted in serially and held in a small linear feedback shift register whose contents drive the oscillator select bus, so one of 256 analog oscillators is addressed at a time. After a start request, the block enables the addressed oscillator and counts its rising edges upward over a fixed window. It then disables the oscillator, steps the register a caller-supplied number of times to address a second oscillator, and counts that one's edges downward over an equal window.

One signed counter therefore accumulates the difference between the two edge counts. Its sign bit is the response bit. Different step counts pair the same challenge with different partner oscillators, so the challenge-to-response mapping can be changed without touching the analog array. The oscillator output arrives asynchronously and is synchronized on entry. Its rate must stay well under half the system clock.

Top module: `ro_puf_sequencer`

## Requirements
- R1: While idle with `loadMode` high, each clock shifts `serialIn` into bit 0 of the 8-bit challenge register and moves every other bit up one place, so after eight clocks the first bit sent sits in bit 7; `oscSel` shows the register at all times.
- R2: `start` is accepted only when idle with `loadMode` low, and `stepCount` is sampled at that moment; `start`, `loadMode` and `serialIn` have no effect while a measurement runs, and a `start` together with `loadMode` high starts nothing.
- R3: If the register holds 8'h00 when `start` is accepted, it is replaced by 8'h01 before the oscillator is enabled; `oscSel` is never zero while `oscEn` is high.
- R4: `oscEn` is low while idle, while a challenge loads and while the register steps; `oscSel` never changes while `oscEn` stays high.
- R5: The first window runs with `oscSel` equal to the loaded challenge. The register is then stepped exactly N = `stepCount` times with next = {q[6:0], q[7]^q[5]^q[4]^q[3]}, and that value is on `oscSel` for the second window and when `done` pulses.
- R6: `response` is 1 when the second oscillator gave more rising edges in its window than the first, and 0 when the first gave more.
- R7: `done` is high for exactly one clock per accepted start; `response` is valid in that clock and holds until the next `done`.
- R8: The same challenge with two different step counts can yield opposite responses.
- R9: `oscIn` passes through a two-stage synchronizer and a rising-edge detector; the signed counter is one bit wider than the largest edge count a window can hold and never wraps.
- R10: After reset `done`, `response` and `oscEn` are 0 and `oscSel` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadMode | input | 1 | High to shift challenge bits in while idle |
| serialIn | input | 1 | Serial challenge bit |
| stepCount | input | 8 | Number of register steps between the two windows |
| start | input | 1 | Request one response measurement |
| oscIn | input | 1 | Asynchronous output of the selected oscillator |
| oscSel | output | 8 | Oscillator address |
| oscEn | output | 1 | Oscillator enable |
| done | output | 1 | One-cycle strobe marking a valid response |
| response | output | 1 | Sign of the up/down edge count |

## Verification
On every clock the assertions hold the select bus frozen while the oscillator runs, keep the enable low during loading and stepping, forbid a zero address under enable, bound the counter away from wrapping, and keep `done` to a single cycle. That the sign bit correctly compares the two oscillators, that the partner oscillator lies exactly N steps away, and that a different N flips the answer can only be shown by the bench's scenarios. In those scenarios, modelled oscillators run at rates tied to their address.

// File: rtl/ro_puf_pkg.sv
package ro_puf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_ARM_A,
    S_WIN_A,
    S_STEP,
    S_ARM_B,
    S_WIN_B,
    S_FINISH
  } puf_state_t;

  typedef struct packed {
    logic shiftIn;
    logic fixZero;
    logic stepLfsr;
    logic clrCnt;
    logic cntUp;
    logic cntDn;
    logic latchResp;
  } puf_ctl_t;

endpackage

// File: rtl/ro_puf_edge_sync.sv
module ro_puf_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic risePulse
);

  logic [STAGES-1:0] chain;
  logic lastQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      lastQ <= 1'b0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      lastQ <= chain[STAGES-1];
    end
  end

  assign risePulse = chain[STAGES-1] & ~lastQ;

endmodule

// File: rtl/ro_puf_ctrl.sv
module ro_puf_ctrl
  import ro_puf_pkg::*;
#(
  parameter int WIN_CYCLES   = 128,
  parameter int STEP_W       = 8,
  parameter int GUARD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              loadMode,
  input  logic [STEP_W-1:0] stepCount,
  output logic              oscEn,
  output puf_ctl_t          ctl
);

  localparam int TIM_W = $clog2(WIN_CYCLES + GUARD_CYCLES + 1);
  localparam logic [TIM_W-1:0] WIN_LAST   = TIM_W'(WIN_CYCLES - 1);
  localparam logic [TIM_W-1:0] GUARD_LAST = TIM_W'(GUARD_CYCLES - 1);

  puf_state_t        stateQ;
  logic [TIM_W-1:0]  timer;
  logic [STEP_W-1:0] stepsLeft;
  logic              timerZero;

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ    <= S_IDLE;
      timer     <= '0;
      stepsLeft <= '0;
    end else begin
      case (stateQ)
        S_IDLE: begin
          if (start && !loadMode) begin
            stateQ    <= S_SETTLE;
            stepsLeft <= stepCount;
          end
        end
        S_SETTLE: begin
          stateQ <= S_ARM_A;
          timer  <= GUARD_LAST;
        end
        S_ARM_A: begin
          if (timerZero) begin
            stateQ <= S_WIN_A;
            timer  <= WIN_LAST;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_WIN_A: begin
          if (timerZero) stateQ <= S_STEP;
          else           timer  <= timer - 1'b1;
        end
        S_STEP: begin
          if (stepsLeft == '0) begin
            stateQ <= S_ARM_B;
            timer  <= GUARD_LAST;
          end else begin
            stepsLeft <= stepsLeft - 1'b1;
          end
        end
        S_ARM_B: begin
          if (timerZero) begin
            stateQ <= S_WIN_B;
            timer  <= WIN_LAST;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_WIN_B: begin
          if (timerZero) stateQ <= S_FINISH;
          else           timer  <= timer - 1'b1;
        end
        S_FINISH: stateQ <= S_IDLE;
        default:  stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.shiftIn   = (stateQ == S_IDLE) && loadMode;
    ctl.fixZero   = (stateQ == S_IDLE) && start && !loadMode;
    ctl.stepLfsr  = (stateQ == S_STEP) && (stepsLeft != '0);
    ctl.clrCnt    = (stateQ == S_ARM_A);
    ctl.cntUp     = (stateQ == S_WIN_A);
    ctl.cntDn     = (stateQ == S_WIN_B);
    ctl.latchResp = (stateQ == S_FINISH);
    oscEn = (stateQ == S_ARM_A) || (stateQ == S_WIN_A) ||
            (stateQ == S_ARM_B) || (stateQ == S_WIN_B);
  end

  // R2: a busy sequencer never re-enters the settle step
  a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != S_IDLE) |=> (stateQ != S_SETTLE));

  // R5: the second window follows the stepping phase only
  a_r5_window_b_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == S_WIN_B) |-> ($past(stateQ) == S_WIN_B || $past(stateQ) == S_ARM_B));

  // R9: at most one counter action per cycle
  a_r9_one_counter_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.clrCnt, ctl.cntUp, ctl.cntDn}));

endmodule

// File: rtl/ro_puf_datapath.sv
module ro_puf_datapath
  import ro_puf_pkg::*;
#(
  parameter int               CHAL_W      = 8,
  parameter logic [CHAL_W-1:0] TAP_MASK   = 8'hB8,
  parameter logic [CHAL_W-1:0] ZERO_FIX   = 8'h01,
  parameter int               CNT_W       = 9,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  puf_ctl_t          ctl,
  input  logic              oscEn,
  input  logic              serialIn,
  input  logic              oscIn,
  output logic [CHAL_W-1:0] oscSel,
  output logic              response,
  output logic              done
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CHAL_W-1:0]       lfsr;
  logic                    feedback;
  logic                    rise;
  logic signed [CNT_W-1:0] cnt;
  logic                    respQ;
  logic                    doneQ;

  assign feedback = ^(lfsr & TAP_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= '0;
    end else if (ctl.shiftIn) begin
      lfsr <= {lfsr[CHAL_W-2:0], serialIn};
    end else if (ctl.fixZero && (lfsr == '0)) begin
      lfsr <= ZERO_FIX;
    end else if (ctl.stepLfsr) begin
      lfsr <= {lfsr[CHAL_W-2:0], feedback};
    end
  end

  ro_puf_edge_sync #(.STAGES(SYNC_STAGES)) uEdge (
    .clk      (clk),
    .rst_n    (rst_n),
    .asyncIn  (oscIn),
    .risePulse(rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctl.clrCnt) begin
      cnt <= '0;
    end else if (ctl.cntUp && rise) begin
      cnt <= cnt + 1'b1;
    end else if (ctl.cntDn && rise) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctl.latchResp;
      if (ctl.latchResp) respQ <= cnt[CNT_W-1];
    end
  end

  assign oscSel   = lfsr;
  assign response = respQ;
  assign done     = doneQ;

  // R4: select frozen for as long as the oscillator stays enabled
  a_r4_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (oscEn && $past(oscEn)) |-> $stable(lfsr));

  // R4: no shifting or stepping with the oscillator running
  a_r4_no_shift_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shiftIn || ctl.stepLfsr) |-> !oscEn);

  // R3: a zero address is never enabled
  a_r3_nonzero_sel: assert property (@(posedge clk) disable iff (!rst_n)
    oscEn |-> (lfsr != '0));

  // R9: counter never wraps in either direction
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cntUp && rise) |-> (cnt != CNT_MAX));
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cntDn && rise) |-> (cnt != CNT_MIN));

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/ro_puf_sequencer.sv
module ro_puf_sequencer #(
  parameter int WIN_CYCLES  = 128,
  parameter int CHAL_W      = 8,
  parameter int STEP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadMode,
  input  logic              serialIn,
  input  logic [STEP_W-1:0] stepCount,
  input  logic              start,
  input  logic              oscIn,
  output logic [CHAL_W-1:0] oscSel,
  output logic              oscEn,
  output logic              done,
  output logic              response
);

  import ro_puf_pkg::*;

  localparam int CNT_W        = $clog2(WIN_CYCLES + 1) + 1;
  localparam int GUARD_CYCLES = SYNC_STAGES + 2;

  puf_ctl_t ctl;

  ro_puf_ctrl #(
    .WIN_CYCLES  (WIN_CYCLES),
    .STEP_W      (STEP_W),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .loadMode (loadMode),
    .stepCount(stepCount),
    .oscEn    (oscEn),
    .ctl      (ctl)
  );

  ro_puf_datapath #(
    .CHAL_W     (CHAL_W),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .oscEn   (oscEn),
    .serialIn(serialIn),
    .oscIn   (oscIn),
    .oscSel  (oscSel),
    .response(response),
    .done    (done)
  );

endmodule

// File: tb/ro_puf_sequencer_test.sv
module ro_puf_sequencer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loadMode = 1'b0;
  logic       serialIn = 1'b0;
  logic [7:0] stepCount = 8'd0;
  logic       start = 1'b0;
  logic       oscIn = 1'b0;
  logic [7:0] oscSel;
  logic       oscEn;
  logic       done;
  logic       response;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ro_puf_sequencer uut (
    .clk(clk), .rst_n(rst_n), .loadMode(loadMode), .serialIn(serialIn),
    .stepCount(stepCount), .start(start), .oscIn(oscIn),
    .oscSel(oscSel), .oscEn(oscEn), .done(done), .response(response)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int halfPeriod(input logic [7:0] s);
    return 2 + (int'(s) % 5);
  endfunction

  function automatic logic [7:0] stepOnce(input logic [7:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  function automatic logic [7:0] stepN(input logic [7:0] q, input int n);
    logic [7:0] v = q;
    for (int i = 0; i < n; i++) v = stepOnce(v);
    return v;
  endfunction

  // mode 0: any different rate, 1: partner slower, 2: partner faster
  function automatic int findN(input logic [7:0] a, input int mode);
    for (int n = 1; n < 256; n++) begin
      int hb = halfPeriod(stepN(a, n));
      int ha = halfPeriod(a);
      if (mode == 0 && hb != ha) return n;
      if (mode == 1 && hb > ha) return n;
      if (mode == 2 && hb < ha) return n;
    end
    return -1;
  endfunction

  // oscillator array model: rate set by the selected address
  int ph = 0;
  always @(negedge clk) begin
    if (!oscEn) begin
      oscIn <= 1'b0;
      ph = 0;
    end else begin
      ph = ph + 1;
      if (ph >= halfPeriod(oscSel)) begin
        oscIn <= ~oscIn;
        ph = 0;
      end
    end
  end

  // reference model of the idle register, compared every clock
  logic [7:0] modelReg = 8'h00;
  bit         idleKnown = 1'b0;
  bit         prevEn = 1'b0;
  logic [7:0] prevSel = 8'h00;

  always @(posedge clk) begin
    if (rst_n && idleKnown && loadMode) modelReg = {modelReg[6:0], serialIn};
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (idleKnown) begin
        check(oscSel == modelReg, "R1", "idle select vs model", int'(oscSel), int'(modelReg));
        if (loadMode) check(!oscEn, "R4", "enable while loading", int'(oscEn), 0);
      end
      if (oscEn && prevEn)
        check(oscSel == prevSel, "R4", "select moved while enabled", int'(oscSel), int'(prevSel));
      prevEn  = oscEn;
      prevSel = oscSel;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic loadChallenge(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) begin
      @(posedge clk); #2;
      loadMode = 1'b1;
      serialIn = c[i];
    end
    @(posedge clk); #2;
    loadMode = 1'b0;
    serialIn = 1'b0;
    @(negedge clk);
    check(oscSel == c, "R1", "loaded challenge", int'(oscSel), int'(c));
  endtask

  task automatic measure(input logic [7:0] chal, input int n, input bit disturb,
                         input string tag, output logic resp);
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] firstSel = 8'h00;
    logic       expResp;
    logic       hold;
    bit         seen = 1'b0;
    bit         gotDone = 1'b0;
    int         cyc = 0;
    a = (chal == 8'h00) ? 8'h01 : chal;
    b = stepN(a, n);
    expResp = (halfPeriod(b) < halfPeriod(a)) ? 1'b1 : 1'b0;
    @(posedge clk); #2;
    stepCount = 8'(n);
    start     = 1'b1;
    idleKnown = 1'b0;
    @(posedge clk); #2;
    start = 1'b0;
    while (!gotDone && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (oscEn && !seen) begin
        seen = 1'b1;
        firstSel = oscSel;
      end
      if (done) gotDone = 1'b1;
      if (disturb) begin
        if (cyc == 20) begin
          loadMode = 1'b1;
          start    = 1'b1;
        end
        if (cyc >= 20 && cyc < 30) serialIn = ~serialIn;
        if (cyc == 22) start = 1'b0;
        if (cyc == 30) begin
          loadMode = 1'b0;
          serialIn = 1'b0;
        end
      end
    end
    check(gotDone, "R7", {tag, " done seen"}, int'(gotDone), 1);
    if (chal == 8'h00)
      check(firstSel == a, "R3", {tag, " zero challenge replaced"}, int'(firstSel), int'(a));
    else
      check(firstSel == a, "R5", {tag, " first window select"}, int'(firstSel), int'(a));
    check(oscSel == b, "R5", {tag, " stepped select"}, int'(oscSel), int'(b));
    check(response == expResp, "R6", {tag, " response sign"}, int'(response), int'(expResp));
    resp = response;
    hold = response;
    modelReg  = b;
    idleKnown = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!done, "R7", {tag, " done single cycle"}, int'(done), 0);
      check(response == hold, "R7", {tag, " response held"}, int'(response), int'(hold));
      if (disturb) check(!oscEn, "R2", {tag, " no restart from ignored start"}, int'(oscEn), 0);
    end
  endtask

  initial begin
    logic r0;
    logic r1;
    logic rx;
    bit   sawActivity;
    int   nA;
    int   nB;

    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !response && !oscEn, "R10", "outputs in reset",
          int'({done, response, oscEn}), 0);
    check(oscSel == 8'h00, "R10", "select in reset", int'(oscSel), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    idleKnown = 1'b1;
    @(negedge clk);
    check(!oscEn && !done, "R10", "idle after reset", int'({oscEn, done}), 0);

    // R1/R5/R6: fast first oscillator
    loadChallenge(8'hB4);
    nA = findN(8'hB4, 0);
    check(nA > 0, "R5", "partner search 0xB4", nA, 1);
    measure(8'hB4, nA, 1'b0, "fast-first", rx);

    // R8: same challenge, two step counts, opposite answers
    loadChallenge(8'h57);
    nA = findN(8'h57, 1);
    nB = findN(8'h57, 2);
    check(nA > 0 && nB > 0, "R8", "partner search 0x57", nA, 1);
    measure(8'h57, nA, 1'b0, "slow-partner", r0);
    loadChallenge(8'h57);
    measure(8'h57, nB, 1'b0, "fast-partner", r1);
    check(r0 != r1, "R8", "step count flips response", int'(r1), int'(~r0));

    // R3: all-zero challenge
    loadChallenge(8'h00);
    nA = findN(8'h01, 0);
    measure(8'h00, nA, 1'b0, "zero", rx);

    // R2: start, loadMode and serialIn ignored during a measurement
    loadChallenge(8'h3C);
    nA = findN(8'h3C, 0);
    measure(8'h3C, nA, 1'b1, "disturbed", rx);

    // R2: start together with loadMode starts nothing
    @(posedge clk); #2;
    loadMode = 1'b1;
    serialIn = 1'b1;
    start    = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    for (int i = 0; i < 7; i++) begin
      serialIn = i[0];
      @(posedge clk); #2;
    end
    loadMode = 1'b0;
    serialIn = 1'b0;
    sawActivity = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (oscEn || done) sawActivity = 1'b1;
    end
    check(!sawActivity, "R2", "start during load ignored", int'(sawActivity), 0);

    // R5/R9: long step count on a full register
    loadChallenge(8'hE1);
    measure(8'hE1, 200, 1'b0, "long-step", rx);

    summary();
    $finish;
  end

endmodule